// File: doc/BRIEF.md
# Debounced External Event Count Gate

This block lets a 24-bit up-counter advance on transitions of an external event pin instead of on prescaled clock ticks. The raw pin is brought into the timer clock domain through a synchroniser. An optional filter then accepts a new level only after that level has been seen on several consecutive samples. The block detects the selected transition direction on the resulting level and emits a single-cycle increment enable for each qualifying transition.

The counter and the compare logic are downstream and consume `cnt_inc` as a plain count-enable strobe. When event mode is off, the strobe stays low and the counter holds its value. Enabling event mode arms the detector one cycle later. A level that was already present when the mode was switched on is therefore never counted.

Top module: `evt_count_front`

## Requirements
- R1: While `rst_n` is low and on the first cycles after its release, `cnt_inc` is 0.
- R2: When `evt_mode_en` is 0, `cnt_inc` stays 0 on the following cycle, whatever `evt_pin` does.
- R3: Each qualifying pin transition produces exactly one `cnt_inc` pulse, one cycle wide. A train of N qualifying transitions produces N pulses.
- R4: With `edge_rise_sel` = 1, only 0-to-1 transitions of the event level qualify. 1-to-0 transitions produce no pulse.
- R5: With `edge_rise_sel` = 0, only 1-to-0 transitions of the event level qualify. 0-to-1 transitions produce no pulse.
- R6: With `deb_en` = 0, a pin change driven before rising clock edge 1 gives `cnt_inc` high after edge 3 and low after edges 2 and 4 (two synchroniser flops plus one output register).
- R7: With `deb_en` = 1, a new level is accepted only after 4 consecutive equal synchronised samples. A pin change held for at least 4 cycles gives `cnt_inc` high after edge 7 and low after edges 6 and 8.
- R8: With `deb_en` = 1, a pin excursion shorter than 4 clock cycles produces no pulse.
- R9: Switching `evt_mode_en` from 0 to 1 produces no pulse in the cycle that follows. A level change that reaches the detector in that same cycle is absorbed, not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 1 | Raw, asynchronous external event pin |
| evt_mode_en | input | 1 | 1 = counter advances on pin events only |
| edge_rise_sel | input | 1 | 1 = rising transitions count, 0 = falling transitions count |
| deb_en | input | 1 | 1 = four-sample filter in the path |
| cnt_inc | output | 1 | One-cycle increment enable for the counter |

## Verification
Without the filter, the pulse for a pin change is due three clock edges after the change: two synchroniser stages and the output register. With the filter, it is due seven edges after the change, because four filter samples and the level register sit between the synchroniser and the output. The bench drives the pin on falling clock edges and samples `cnt_inc` on the falling edges after edges 2, 3 and 4, and after edges 6, 7 and 8. It checks that the pulse lands on the expected edge and is absent on its neighbours. The vector runs count pulses over a window that ends well after the last possible due cycle, so each counted total covers every pulse a stimulus can cause.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  // Default structure of the event front end
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned DEB_SAMPLES_DEF = 4;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/evtc_sync.sv
module evtc_sync #(
  parameter int unsigned STAGES = evtc_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[TOP-1:0], din};
  end

  assign dout = chain[TOP];
endmodule

// File: rtl/evtc_debounce.sv
module evtc_debounce #(
  parameter int unsigned SAMPLES = evtc_pkg::DEB_SAMPLES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          held;
  logic [CW-1:0] run;

  // held moves to a new level only after SAMPLES consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      run  <= '0;
    end else if (!en) begin
      held <= din;
      run  <= '0;
    end else if (din == held) begin
      run  <= '0;
    end else if (run == LAST) begin
      held <= din;
      run  <= '0;
    end else begin
      run  <= run + 1'b1;
    end
  end

  assign dout = en ? held : din;
endmodule

// File: rtl/evtc_edge.sv
module evtc_edge
  import evtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic mode_en,
  input  logic rise_sel,
  output logic pulse
);
  edge_sel_e want;
  logic      prev;
  logic      armed;
  logic      hit;

  assign want = edge_sel_e'(rise_sel);
  assign hit  = (level != prev) && (level == logic'(want));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      armed <= 1'b0;
      pulse <= 1'b0;
    end else begin
      prev  <= level;
      armed <= mode_en;
      pulse <= mode_en && armed && hit;
    end
  end
endmodule

// File: rtl/evt_count_front.sv
module evt_count_front #(
  parameter int unsigned SYNC_STAGES = evtc_pkg::SYNC_STAGES_DEF,
  parameter int unsigned DEB_SAMPLES = evtc_pkg::DEB_SAMPLES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_pin,
  input  logic evt_mode_en,
  input  logic edge_rise_sel,
  input  logic deb_en,
  output logic cnt_inc
);
  logic sync_w;
  logic level_w;

  evtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (evt_pin),
    .dout (sync_w)
  );

  evtc_debounce #(.SAMPLES(DEB_SAMPLES)) u_deb (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (deb_en),
    .din  (sync_w),
    .dout (level_w)
  );

  evtc_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (level_w),
    .mode_en (evt_mode_en),
    .rise_sel(edge_rise_sel),
    .pulse   (cnt_inc)
  );
endmodule

// File: rtl/evtc_checker.sv
module evtc_checker #(
  parameter int unsigned SAMPLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic rise_sel,
  input logic filt_en,
  input logic sync_lvl,
  input logic filt_lvl,
  input logic inc
);
  logic        prev_s;
  logic [31:0] run;
  logic [31:0] cur_run;

  // length of the current streak of equal synchronised samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b0;
      run    <= '0;
    end else begin
      prev_s <= sync_lvl;
      if (sync_lvl == prev_s) run <= (run < SAMPLES) ? run + 1 : run;
      else                    run <= 32'd1;
    end
  end

  assign cur_run = (sync_lvl == prev_s) ? run + 1 : 32'd1;

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (inc == 1'b0);
  end

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !inc);

  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> !inc);

  // R4 / R5: a pulse follows a transition toward the selected level
  assert_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> ($past(filt_lvl) == $past(rise_sel)) && ($past(filt_lvl) != $past(filt_lvl, 2)));

  assert_filter_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && (filt_lvl != $past(filt_lvl))) |-> ($past(cur_run) >= SAMPLES));

  assert_arm_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_en) |=> !inc);
endmodule

bind evt_count_front evtc_checker #(.SAMPLES(DEB_SAMPLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_en (evt_mode_en),
  .rise_sel(edge_rise_sel),
  .filt_en (deb_en),
  .sync_lvl(sync_w),
  .filt_lvl(level_w),
  .inc     (cnt_inc)
);

// File: tb/sim_evt_count_front.sv
module sim_evt_count_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_pin = 1'b0;
  logic evt_mode_en = 1'b0;
  logic edge_rise_sel = 1'b1;
  logic deb_en = 1'b0;
  logic cnt_inc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evt_count_front u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_pin      (evt_pin),
    .evt_mode_en  (evt_mode_en),
    .edge_rise_sel(edge_rise_sel),
    .deb_en       (deb_en),
    .cnt_inc      (cnt_inc)
  );

  // {rise, filter, hold cycles[5:0], expected pulses[3:0], requirement[3:0]}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd1, 4'd1, 4'd4},
    {1'b1, 1'b0, 6'd5, 4'd1, 4'd3},
    {1'b0, 1'b0, 6'd2, 4'd1, 4'd5},
    {1'b0, 1'b0, 6'd6, 4'd1, 4'd5},
    {1'b1, 1'b1, 6'd3, 4'd0, 4'd8},
    {1'b1, 1'b1, 6'd4, 4'd1, 4'd7},
    {1'b1, 1'b1, 6'd8, 4'd1, 4'd7},
    {1'b0, 1'b1, 6'd2, 4'd0, 4'd8},
    {1'b0, 1'b1, 6'd5, 4'd1, 4'd7}
  };

  function automatic string rtag(input int r);
    case (r)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      8: return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // mode off, set polarity/filter, settle at idle level, then arm
  task automatic setup(input logic rise, input logic filt);
    @(negedge clk);
    evt_mode_en   = 1'b0;
    edge_rise_sel = rise;
    deb_en        = filt;
    evt_pin       = !rise;
    repeat (10) @(negedge clk);
    evt_mode_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // after setup: drive pin change now, return inc as seen after edges 1..n
  task automatic latency(input int n, output logic [15:0] seen);
    seen = '0;
    evt_pin = edge_rise_sel;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      seen[k] = cnt_inc;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int cnt;
    logic [15:0] seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", cnt_inc, 0, "during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cnt_inc, 0, "after reset release");

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic rise;
      int   len;
      rise = VEC[v][15];
      len  = int'(VEC[v][13:8]);
      setup(rise, VEC[v][14]);
      cnt = 0;
      for (int i = 0; i < len + 16; i++) begin
        @(negedge clk);
        if (cnt_inc) cnt++;
        evt_pin = (i < len) ? rise : !rise;
      end
      check(rtag(int'(VEC[v][3:0])), cnt, int'(VEC[v][7:4]), $sformatf("vector %0d pulse count", v));
    end

    // R2: event mode off, pin toggling
    setup(1'b1, 1'b0);
    evt_mode_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnt_inc) cnt++;
      if (i % 4 == 0) evt_pin = !evt_pin;
    end
    check("R2", cnt, 0, "pulses with mode off");

    // R3: train of four rising transitions
    setup(1'b1, 1'b0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnt_inc) cnt++;
      if (i < 24 && i % 3 == 0) evt_pin = !evt_pin;
    end
    check("R3", cnt, 4, "pulses for four rising transitions");

    // R4: falling transition ignored when rising selected
    setup(1'b1, 1'b0);
    evt_pin = 1'b1;
    repeat (8) @(negedge clk);
    cnt = 0;
    evt_pin = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnt_inc) cnt++;
    end
    check("R4", cnt, 0, "falling transition with rising selected");

    // R6: unfiltered latency
    setup(1'b1, 1'b0);
    latency(5, seen);
    check("R6", seen[2], 0, "inc after edge 2");
    check("R6", seen[3], 1, "inc after edge 3");
    check("R6", seen[4], 0, "inc after edge 4");

    // R7: filtered latency
    setup(1'b0, 1'b1);
    latency(9, seen);
    check("R7", seen[6], 0, "inc after edge 6");
    check("R7", seen[7], 1, "inc after edge 7");
    check("R7", seen[8], 0, "inc after edge 8");

    // R9: level already at selected value when mode is switched on
    @(negedge clk);
    evt_mode_en = 1'b0;
    edge_rise_sel = 1'b1;
    deb_en = 1'b0;
    evt_pin = 1'b1;
    repeat (6) @(negedge clk);
    evt_mode_en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnt_inc) cnt++;
    end
    check("R9", cnt, 0, "enable with pin already high");

    // R9: level reaches detector in the cycle mode is switched on
    @(negedge clk);
    evt_mode_en = 1'b0;
    evt_pin = 1'b0;
    repeat (6) @(negedge clk);
    evt_pin = 1'b1;
    repeat (2) @(negedge clk);
    evt_mode_en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnt_inc) cnt++;
    end
    check("R9", cnt, 0, "enable in the cycle the edge arrives");

    finish_run();
  end
endmodule